// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block arbitrates interrupt requests for a small 8-bit processor core. One asynchronous external pin and a set of internal single-cycle event pulses (a parameterised number of counter-overflow events plus one periodic tick) each raise a request flag. Software reads and writes two 8-bit control words: one holds the master enable and the per-source enables, the other holds the request flags.

When the master enable is set, the core's return stack has room, and at least one enabled flag is pending, the block accepts the highest-priority pending source. For one cycle it tells the core to push its program counter and jump to that source's vector address. At the same time it clears the accepted flag and the master enable. A return strobe from the core is passed back as a pop command and sets the master enable again.

Top module: `int_vec_ctrl`

## Requirements
- R1: After reset the master enable, all source enables and all request flags are 0, `take_irq` is 0 and `vec_addr` is 0.
- R2: An event pulse sets its source's flag whether or not the source or the master enable is set. Masked requests stay latched until serviced or cleared by software.
- R3: The external pin passes through two synchroniser flops. A 0-to-1 transition sets the external flag once, three clock edges after the pin rises. A pin held high does not set it again.
- R4: `take_irq` pulses for exactly one cycle, in the cycle after an edge at which the master enable was 1, `stack_full` was 0 and some flag had its enable set. A pending flag whose enable is 0 is never accepted.
- R5: Priority and vector index: source 0 is the external pin (highest), sources 1..N_TMR are the overflow events in index order, and source N_TMR+1 is the tick (lowest). `vec_addr` = VEC_BASE + index*VEC_STRIDE (defaults 4, 8, 12, 16) and holds between acceptances.
- R6: Acceptance clears only the accepted source's flag. Other pending flags remain set.
- R7: Acceptance clears the master enable, so no further acceptance occurs until it is set again.
- R8: While `stack_full` is 1 nothing is accepted. Acceptance proceeds in the cycle after `stack_full` drops.
- R9: `pop_pc` follows `irq_return` in the same cycle. A return strobe sets the master enable at the next edge, unless an acceptance or a control write happens at that edge.
- R10: Register map: `reg_sel`=0 selects the control word (bit 0 = master enable, bit 1+i = enable of source i), `reg_sel`=1 selects the flag word (bit i = flag of source i). Reads are combinational. A flag write replaces the flags, but an event in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | N_TMR | Counter-overflow event pulses |
| tick | input | 1 | Periodic tick event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = flag word |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected word |
| stack_full | input | 1 | Return stack of the core is full |
| irq_return | input | 1 | Return-from-interrupt strobe from the core |
| take_irq | output | 1 | Push program counter and load vector |
| vec_addr | output | AW | Vector address of the accepted source |
| pop_pc | output | 1 | Pop saved program counter |

## Verification
A flag lost or set twice shows up in the flag word at the next read, and as a missing or extra `take_irq` one cycle after the master enable allows acceptance. A stale master enable shows up as a second acceptance one cycle after the first. A wrong arbitration index shows up in `vec_addr` in the same cycle as the pulse. The bench compares a behavioural model with every port on every clock, so each such fault is reported within one to two cycles.

// File: rtl/int_vec_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes one register select bit addressing two 8-bit-class words.
package int_vec_pkg;
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_FLAG = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/int_edge_sync.sv
// Synchronises an asynchronous pin through STAGES flops and flags a
// 0-to-1 transition of the synchronised level as a one-cycle pulse.
// Assumes the pin is stable for at least one clock between changes.
module int_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] chain;

    // Shift the pin through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/int_prio_pick.sv
// Fixed-priority arbiter: the lowest-numbered requesting source wins.
// Produces a one-hot grant, the winner's index and an any-request flag.
module int_prio_pick #(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [IW-1:0]   idx,
    output logic            any
);
    logic [NSRC:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign grant[g]  = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[NSRC];

    // Encode the winner's index, scanning so the lowest index wins.
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/int_flag_bank.sv
// Holds request flags, per-source enables and the master enable.
// Events always set flags; acceptance clears the granted flag and the
// master enable; a return strobe restores the master enable.
module int_flag_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] events,
    input  logic            wr_ctrl,
    input  logic            wr_flag,
    input  logic [NSRC:0]   wdata,
    input  logic            take,
    input  logic [NSRC-1:0] grant,
    input  logic            ret,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] enables,
    output logic            gie
);
    logic [NSRC-1:0] flag_base;
    logic [NSRC-1:0] clr_mask;

    // Pick the software-written or held value and the acceptance clear.
    always_comb begin
        flag_base = wr_flag ? wdata[NSRC-1:0] : flags;
        clr_mask  = take ? grant : '0;
    end

    // Update flags: clear on acceptance, events win over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flag_base & ~clr_mask) | events;
    end

    // Update per-source enables from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       enables <= '0;
        else if (wr_ctrl) enables <= wdata[NSRC:1];
    end

    // Update master enable: acceptance, then write, then return.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie <= 1'b0;
        else if (take)    gie <= 1'b0;
        else if (wr_ctrl) gie <= wdata[0];
        else if (ret)     gie <= 1'b1;
    end
endmodule

// File: rtl/int_vec_ctrl.sv
// Vectored interrupt controller top. Sources: external pin (index 0),
// N_TMR overflow pulses (1..N_TMR), tick (N_TMR+1). Accepts one source
// when enabled and the return stack is not full, issuing a one-cycle
// push/vector command. Assumes DW >= N_TMR + 3.
module int_vec_ctrl #(
    parameter int N_TMR      = 2,
    parameter int DW         = 8,
    parameter int AW         = 11,
    parameter int VEC_BASE   = 4,
    parameter int VEC_STRIDE = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             stack_full,
    input  logic             irq_return,
    output logic             take_irq,
    output logic [AW-1:0]    vec_addr,
    output logic             pop_pc
);
    import int_vec_pkg::*;

    localparam int NSRC = N_TMR + 2;
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            ext_rise;
    logic [NSRC-1:0] events;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] enables;
    logic [NSRC-1:0] grant;
    logic [IW-1:0]   win_idx;
    logic            any_req;
    logic            gie;
    logic            take;
    logic            wr_ctrl;
    logic            wr_flag;

    wire unused_wdata_hi = ^reg_wdata[DW-1:NSRC+1];

    int_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (ext_rise)
    );

    assign events  = {tick, tmr_ovf, ext_rise};
    assign wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_flag = reg_wr && (reg_sel_e'(reg_sel) == SEL_FLAG);

    int_flag_bank #(.NSRC(NSRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .wr_ctrl(wr_ctrl),
        .wr_flag(wr_flag),
        .wdata  (reg_wdata[NSRC:0]),
        .take   (take),
        .grant  (grant),
        .ret    (irq_return),
        .flags  (flags),
        .enables(enables),
        .gie    (gie)
    );

    int_prio_pick #(.NSRC(NSRC)) u_pick (
        .req  (flags & enables),
        .grant(grant),
        .idx  (win_idx),
        .any  (any_req)
    );

    assign take = gie && !stack_full && any_req;

    // Register the push/vector command and the vector of the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_irq <= 1'b0;
            vec_addr <= '0;
        end else begin
            take_irq <= take;
            if (take)
                vec_addr <= AW'(VEC_BASE) + AW'(win_idx) * AW'(VEC_STRIDE);
        end
    end

    // Select the read word.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel_e'(reg_sel) == SEL_CTRL) reg_rdata[NSRC:0]   = {enables, gie};
        else                                 reg_rdata[NSRC-1:0] = flags;
    end

    assign pop_pc = irq_return;
endmodule

// File: rtl/int_vec_ctrl_chk.sv
// Assertion checker bound to the interrupt controller top.
module int_vec_ctrl_chk #(
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stack_full,
    input logic            irq_return,
    input logic            take_irq,
    input logic            take,
    input logic            wr_ctrl,
    input logic            gie,
    input logic [NSRC-1:0] grant
);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    a_r8_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(stack_full));

    a_r7_gie_off_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !gie);

    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !take && !wr_ctrl) |=> gie);
endmodule

bind int_vec_ctrl int_vec_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stack_full(stack_full),
    .irq_return(irq_return),
    .take_irq  (take_irq),
    .take      (take),
    .wr_ctrl   (wr_ctrl),
    .gie       (gie),
    .grant     (grant)
);

// File: tb/int_vec_ctrl_bench.sv
module int_vec_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_TMR = 2;
    localparam int NSRC  = N_TMR + 2;
    localparam int DW = 8;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin = 1'b0;
    logic [N_TMR-1:0] tmr_ovf = '0;
    logic tick = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_sel = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic stack_full = 1'b0;
    logic irq_return = 1'b0;
    logic take_irq;
    logic [AW-1:0] vec_addr;
    logic pop_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int_vec_ctrl u_int_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stack_full(stack_full), .irq_return(irq_return),
        .take_irq(take_irq), .vec_addr(vec_addr), .pop_pc(pop_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_flag = 0, m_en = 0, m_gie = 0, m_ack = 0, m_vec = 0;
    int pin_h1 = 0, pin_h2 = 0, pin_h3 = 0;

    always @(posedge clk) begin : model
        int ev, pend, win, nf;
        if (!rst_n) begin
            m_flag = 0; m_en = 0; m_gie = 0; m_ack = 0; m_vec = 0;
            pin_h1 = 0; pin_h2 = 0; pin_h3 = 0;
        end else begin
            ev = (pin_h2 && !pin_h3) ? 1 : 0;
            ev = ev | (int'(tmr_ovf) << 1) | (int'(tick) << (NSRC - 1));
            pin_h3 = pin_h2; pin_h2 = pin_h1; pin_h1 = int'(ext_pin);
            pend = m_flag & m_en;
            win = -1;
            for (int k = NSRC - 1; k >= 0; k--) if (pend[k]) win = k;
            nf = (reg_wr && reg_sel) ? int'(reg_wdata) & ((1 << NSRC) - 1) : m_flag;
            m_ack = (m_gie != 0 && !stack_full && win >= 0) ? 1 : 0;
            if (m_ack != 0) begin
                nf = nf & ~(1 << win);
                m_vec = 4 + 4 * win;
                m_gie = 0;
            end else if (reg_wr && !reg_sel) m_gie = int'(reg_wdata[0]);
            else if (irq_return) m_gie = 1;
            if (reg_wr && !reg_sel) m_en = int'(reg_wdata[NSRC:1]);
            m_flag = nf | ev;
        end
    end

    // Compare every port with the model once per clock.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R4 take_irq vs model", int'(take_irq), m_ack);
            chk("R5 vec_addr vs model", int'(vec_addr), m_vec);
            chk("R9 pop_pc vs model", int'(pop_pc), int'(irq_return));
            chk("R10 reg_rdata vs model", int'(reg_rdata),
                reg_sel ? m_flag : ((m_en << 1) | m_gie));
        end
    end

    task automatic wr(input bit sel, input int d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = DW'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit sel, input string req, input int exp);
        reg_sel = sel;
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    task automatic ret_strobe();
        irq_return = 1'b1;
        #1;
        chk("R9 pop_pc follows return", int'(pop_pc), 1);
        @(negedge clk);
        irq_return = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        rd(0, "R1 control word after reset", 0);
        rd(1, "R1 flag word after reset", 0);
        chk("R1 take_irq after reset", int'(take_irq), 0);
        chk("R1 vec_addr after reset", int'(vec_addr), 0);

        // R2 masked events latch
        tmr_ovf[0] = 1'b1; @(negedge clk); tmr_ovf[0] = 1'b0;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        rd(1, "R2 masked flags latched", 'b1010);

        // R5/R6/R7 acceptance of counter 0 over tick
        wr(0, 'h15);
        #1 chk("R4 no take before enable seen", int'(take_irq), 0);
        nxt();
        chk("R5 take for counter 0", int'(take_irq), 1);
        chk("R5 vector of counter 0", int'(vec_addr), 8);
        rd(0, "R7 master enable cleared", 'h14);
        rd(1, "R6 only granted flag cleared", 'b1000);
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R7 no further take while disabled", int'(take_irq), 0);
        end

        // R9 return restores enable; tick then accepted
        @(negedge clk);
        ret_strobe();
        rd(0, "R9 master enable restored", 'h15);
        nxt();
        chk("R9 take after return", int'(take_irq), 1);
        chk("R5 vector of tick", int'(vec_addr), 16);
        rd(1, "R6 flags empty", 0);

        // R8 stack full blocks; R3 pin edge
        @(negedge clk);
        stack_full = 1'b1;
        wr(0, 'h17);
        ext_pin = 1'b1;
        for (int i = 0; i < 4; i++) begin
            nxt();
            chk("R8 no take while stack full", int'(take_irq), 0);
        end
        rd(1, "R3 external flag set", 1);
        stack_full = 1'b0;
        nxt();
        chk("R8 take after stack frees", int'(take_irq), 1);
        chk("R5 vector of external pin", int'(vec_addr), 4);
        rd(1, "R3 external flag cleared", 0);
        repeat (4) @(negedge clk);
        rd(1, "R3 held pin no retrigger", 0);

        // R10 event wins over same-cycle flag write
        @(negedge clk);
        tmr_ovf[0] = 1'b1;
        wr(1, 0);
        tmr_ovf[0] = 1'b0;
        rd(1, "R10 event beats flag write", 'b0010);

        // R5 priority ordering across three sources
        wr(1, 'b1101);
        rd(1, "R10 flag write replaces", 'b1101);
        wr(0, 'h1F);
        nxt();
        chk("R5 external first", int'(vec_addr), 4);
        @(negedge clk);
        ret_strobe();
        nxt();
        chk("R5 counter 1 second", int'(vec_addr), 12);
        @(negedge clk);
        ret_strobe();
        nxt();
        chk("R5 tick last", int'(vec_addr), 16);

        // R4 disabled pending flag never accepted
        @(negedge clk);
        wr(0, 'h01);
        tmr_ovf[1] = 1'b1; @(negedge clk); tmr_ovf[1] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R4 disabled source not taken", int'(take_irq), 0);
        end
        rd(0, "R4 master enable untouched", 1);
        rd(1, "R2 disabled flag latched", 'b0100);

        @(negedge clk);
        summary();
    end
endmodule